// File: doc/BRIEF.md
# Locality Claim and Release Sequencer

This block takes ownership of locality 0 of a trusted-module register interface, and gives it back, by driving a simple byte-wide register bus as master. The interface has two registers. The access register is at `ACC_ADDR`, and its bit 5 reports that the locality is active. The status register is at `STS_ADDR`, and writing 0x40 to it arms the module for a command. An open request always starts with a conditional release. The block reads the access register and, if the locality is held, writes 0x20 and polls until the active bit clears. It then writes 0x02 to request use, polls until the active bit is set, and finishes by writing 0x40 to the status register. A close request runs only the conditional release.

Each poll phase is bounded. Reads are separated by `POLL_GAP` idle cycles, and a phase gives up after `POLL_MAX` reads that do not match. The defaults give roughly one second of 1 µs-spaced reads at 200 MHz. The block ends every accepted request with a one-cycle `done` pulse or a one-cycle `err` pulse. `busy` is high while a request is in progress.

Top module: `loc_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `err` and `bus_valid` are all 0.
- R2: A pulse on `open_req` or `close_req` is accepted only while `busy` is 0. If both arrive in the same cycle, the open is run. Any request that arrives while `busy` is 1 is ignored and causes no bus traffic and no extra `done`.
- R3: Every request first reads the access register at `ACC_ADDR`. If bit 5 (active) reads 1, the block writes 0x20 to `ACC_ADDR` and polls `ACC_ADDR` until a read returns bit 7 (register valid) = 1 and bit 5 = 0. If bit 5 reads 0 on the first read, no 0x20 write occurs.
- R4: An open request, after the release step, writes 0x02 to `ACC_ADDR` and then polls until a read returns bit 7 = 1 and bit 5 = 1.
- R5: Once the grant is seen, an open writes 0x40 to `STS_ADDR` exactly once and then pulses `done`.
- R6: A close request performs only the release step and then pulses `done`. It never writes 0x02 or 0x40.
- R7: In a poll phase, consecutive reads are at least `POLL_GAP` cycles apart. The phase fails on the `POLL_MAX`-th non-matching read, so a value that first appears on read number `POLL_MAX` still succeeds. On failure the block pulses `err` and issues no further writes.
- R8: `busy` rises in the cycle after a request is accepted and falls in the same cycle that `done` or `err` pulses. `done` and `err` last one cycle each and never coincide.
- R9: Once `bus_valid` rises, it stays high, with `bus_write`, `bus_addr` and `bus_wdata` stable, until the cycle in which `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Single-cycle pulse that requests claiming locality 0 |
| close_req | input | 1 | Single-cycle pulse that requests releasing locality 0 |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on a poll timeout |
| bus_valid | output | 1 | Bus transfer pending; held until acknowledged |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer complete; read data valid in this cycle |
| bus_rdata | input | 8 | Read data |

## Verification
The bound checker watches the handshake-level rules on every cycle. These are the bus hold rule, the values allowed in writes to the access register, the pulse shape and exclusivity of `done` and `err`, and the way `busy` starts on acceptance and stops together with the completion pulse. The bench's register model is needed for everything that depends on what the register returns over time. That covers whether the release write is skipped, the order of the request and arm writes, success at exactly `POLL_MAX` reads against failure one read later, the spacing between poll reads, and whether requests made while busy leave the register state untouched.

// File: rtl/loc_pkg.sv
package loc_pkg;
  localparam int ACT_BIT = 5;
  localparam int VLD_BIT = 7;
  localparam logic [7:0] REL_CMD = 8'h20;
  localparam logic [7:0] REQ_CMD = 8'h02;
  localparam logic [7:0] RDY_CMD = 8'h40;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ACC, S_REL_WR, S_REL_POLL, S_REL_GAP,
    S_REQ_WR, S_GNT_POLL, S_GNT_GAP, S_RDY_WR
  } seq_t;
endpackage

// File: rtl/loc_bus_port.sv
module loc_bus_port #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              fin,
  output logic [7:0]        rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      fin       <= 1'b0;
      rdata     <= '0;
    end else begin
      fin <= 1'b0;
      if (!bus_valid && start) begin
        bus_valid <= 1'b1;
        bus_write <= wr;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (bus_valid && bus_ack) begin
        bus_valid <= 1'b0;
        fin       <= 1'b1;
        rdata     <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/loc_poll_timer.sv
module loc_poll_timer #(
  parameter int POLL_GAP = 200,
  parameter int POLL_MAX = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic miss,
  output logic gap_done,
  output logic last
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int TW = $clog2(POLL_MAX + 1);

  logic [GW-1:0] gcnt;
  logic          run;
  logic [TW-1:0] tries;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt     <= '0;
      run      <= 1'b0;
      tries    <= '0;
      gap_done <= 1'b0;
    end else begin
      gap_done <= 1'b0;
      if (restart)   tries <= '0;
      else if (miss) tries <= tries + 1'b1;
      if (miss) begin
        run  <= 1'b1;
        gcnt <= GW'(POLL_GAP - 1);
      end else if (run) begin
        if (gcnt == '0) begin
          run      <= 1'b0;
          gap_done <= 1'b1;
        end else begin
          gcnt <= gcnt - 1'b1;
        end
      end
    end
  end

  assign last = (tries == TW'(POLL_MAX - 1));
endmodule

// File: rtl/loc_ctrl.sv
module loc_ctrl
  import loc_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] ACC_ADDR = 12'h000,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h018,
  parameter int              POLL_GAP = 200,
  parameter int              POLL_MAX = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_req,
  input  logic              close_req,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);
  seq_t              state;
  logic              mode_open;
  logic              issued;
  logic              x_start, x_wr, x_fin;
  logic [ADDR_W-1:0] x_addr;
  logic [7:0]        x_wdata, x_rdata;
  logic              gap_done, last;
  logic              is_poll, want_act, hit;
  logic              unused_bits;

  always_comb begin
    x_wr    = 1'b0;
    x_addr  = ACC_ADDR;
    x_wdata = 8'h00;
    x_start = 1'b0;
    unique case (state)
      S_RD_ACC, S_REL_POLL, S_GNT_POLL: x_start = !issued;
      S_REL_WR: begin x_start = !issued; x_wr = 1'b1; x_wdata = REL_CMD; end
      S_REQ_WR: begin x_start = !issued; x_wr = 1'b1; x_wdata = REQ_CMD; end
      S_RDY_WR: begin
        x_start = !issued; x_wr = 1'b1; x_wdata = RDY_CMD; x_addr = STS_ADDR;
      end
      default: ;
    endcase
  end

  assign is_poll  = (state == S_REL_POLL) || (state == S_GNT_POLL);
  assign want_act = (state == S_GNT_POLL);
  assign hit      = x_rdata[VLD_BIT] && (x_rdata[ACT_BIT] == want_act);
  assign unused_bits = ^{x_rdata[6], x_rdata[4:0]};

  loc_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst),
    .start(x_start), .wr(x_wr), .addr(x_addr), .wdata(x_wdata),
    .fin(x_fin), .rdata(x_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  loc_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)) u_timer (
    .clk(clk), .rst(rst),
    .restart(x_fin && (state == S_REL_WR || state == S_REQ_WR)),
    .miss(x_fin && is_poll && !hit),
    .gap_done(gap_done), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) issued <= 1'b0;
    else if (x_start) issued <= 1'b1;
    else if (x_fin) issued <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mode_open <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (open_req || close_req) begin
          busy      <= 1'b1;
          mode_open <= open_req;
          state     <= S_RD_ACC;
        end
        S_RD_ACC: if (x_fin) begin
          if (x_rdata[ACT_BIT]) state <= S_REL_WR;
          else if (mode_open)   state <= S_REQ_WR;
          else begin state <= S_IDLE; busy <= 1'b0; done <= 1'b1; end
        end
        S_REL_WR: if (x_fin) state <= S_REL_POLL;
        S_REL_POLL: if (x_fin) begin
          if (hit) begin
            if (mode_open) state <= S_REQ_WR;
            else begin state <= S_IDLE; busy <= 1'b0; done <= 1'b1; end
          end else if (last) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else state <= S_REL_GAP;
        end
        S_REL_GAP: if (gap_done) state <= S_REL_POLL;
        S_REQ_WR: if (x_fin) state <= S_GNT_POLL;
        S_GNT_POLL: if (x_fin) begin
          if (hit) state <= S_RDY_WR;
          else if (last) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else state <= S_GNT_GAP;
        end
        S_GNT_GAP: if (gap_done) state <= S_GNT_POLL;
        S_RDY_WR: if (x_fin) begin
          state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loc_ctrl_chk.sv
module loc_ctrl_chk #(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] ACC_ADDR = 12'h000
) (
  input logic              clk,
  input logic              rst,
  input logic              open_req,
  input logic              close_req,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_ack
);
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) &&
                                 $stable(bus_wdata) && $stable(bus_write)));

  a_r3_acc_values: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ACC_ADDR) |->
      (bus_wdata == 8'h20 || bus_wdata == 8'h02));

  a_r8_excl: assert property (@(posedge clk) disable iff (rst) !(done && err));

  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    (done || err) |=> !(done || err));

  a_r8_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || err));

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && (open_req || close_req)) |=> busy);
endmodule

bind loc_ctrl loc_ctrl_chk #(.ADDR_W(ADDR_W), .ACC_ADDR(ACC_ADDR)) u_chk (
  .clk(clk), .rst(rst), .open_req(open_req), .close_req(close_req),
  .busy(busy), .done(done), .err(err), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ack(bus_ack)
);

// File: tb/sim_loc_ctrl.sv
`timescale 1ns/100ps
module sim_loc_ctrl;
  localparam int AW  = 12;
  localparam logic [AW-1:0] ACC = 12'h000;
  localparam logic [AW-1:0] STS = 12'h018;
  localparam int GAP = 10;
  localparam int MAXP = 8;

  typedef struct packed {
    logic       op;     // 1 open, 0 close
    logic       act0;
    logic [7:0] rd;
    logic [7:0] gd;
    logic       e_err;
    logic       e_act;
    logic [1:0] e_rel;
    logic [1:0] e_req;
    logic [1:0] e_rdy;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 2'd0, 2'd1, 2'd1},
    '{1'b1, 1'b1, 8'd0,   8'd3,   1'b0, 1'b1, 2'd1, 2'd1, 2'd1},
    '{1'b1, 1'b1, 8'd7,   8'd7,   1'b0, 1'b1, 2'd1, 2'd1, 2'd1},
    '{1'b1, 1'b1, 8'd8,   8'd0,   1'b1, 1'b0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 1'b0, 8'd0,   8'd8,   1'b1, 1'b1, 2'd0, 2'd1, 2'd0},
    '{1'b1, 1'b0, 8'd0,   8'd255, 1'b1, 1'b0, 2'd0, 2'd1, 2'd0},
    '{1'b0, 1'b1, 8'd2,   8'd0,   1'b0, 1'b0, 2'd1, 2'd0, 2'd0},
    '{1'b0, 1'b0, 8'd0,   8'd0,   1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'd255, 8'd0,   1'b1, 1'b1, 2'd1, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic open_req = 1'b0, close_req = 1'b0;
  logic busy, done, err, bus_valid, bus_write, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  loc_ctrl #(.ADDR_W(AW), .ACC_ADDR(ACC), .STS_ADDR(STS),
             .POLL_GAP(GAP), .POLL_MAX(MAXP)) u0 (
    .clk(clk), .rst(rst), .open_req(open_req), .close_req(close_req),
    .busy(busy), .done(done), .err(err), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // register model
  logic ld = 1'b0, ld_act = 1'b0;
  logic [7:0] ld_rd = '0, ld_gd = '0;
  logic m_act, rd_seen;
  logic [7:0] rel_d, gnt_d, rel_left, gnt_left;
  int n_rel, n_req, n_rdy, n_bad, n_fin;
  logic [15:0] cyc, last_rd, min_gap;

  assign bus_rdata = {1'b1, 1'b0, m_act, 5'b0};

  always_ff @(posedge clk) begin
    cyc <= (rst) ? 16'd0 : cyc + 16'd1;
    if (ld) begin
      m_act <= ld_act; rel_d <= ld_rd; gnt_d <= ld_gd;
      rel_left <= '0; gnt_left <= '0; bus_ack <= 1'b0;
      n_rel <= 0; n_req <= 0; n_rdy <= 0; n_bad <= 0; n_fin <= 0;
      min_gap <= 16'hffff; last_rd <= '0; rd_seen <= 1'b0;
    end else begin
      if (done || err) n_fin <= n_fin + 1;
      bus_ack <= bus_valid && !bus_ack;
      if (bus_valid && bus_ack) begin
        if (bus_write) begin
          rd_seen <= 1'b0;
          if (bus_addr == ACC && bus_wdata == 8'h20) begin
            n_rel <= n_rel + 1;
            if (rel_d == 0) m_act <= 1'b0; else rel_left <= rel_d;
          end else if (bus_addr == ACC && bus_wdata == 8'h02) begin
            n_req <= n_req + 1;
            if (gnt_d == 0) m_act <= 1'b1; else gnt_left <= gnt_d;
          end else if (bus_addr == STS && bus_wdata == 8'h40) n_rdy <= n_rdy + 1;
          else n_bad <= n_bad + 1;
        end else begin
          if (bus_addr != ACC) n_bad <= n_bad + 1;
          if (rel_left != 0) begin
            rel_left <= rel_left - 8'd1;
            if (rel_left == 8'd1) m_act <= 1'b0;
          end
          if (gnt_left != 0) begin
            gnt_left <= gnt_left - 8'd1;
            if (gnt_left == 8'd1) m_act <= 1'b1;
          end
          if (rd_seen && (cyc - last_rd) < min_gap) min_gap <= cyc - last_rd;
          last_rd <= cyc;
          rd_seen <= 1'b1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic a, input logic [7:0] r, input logic [7:0] g);
    @(negedge clk); ld = 1'b1; ld_act = a; ld_rd = r; ld_gd = g;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic pulse(input logic o, input logic c);
    @(negedge clk); open_req = o; close_req = c;
    @(negedge clk); open_req = 1'b0; close_req = 1'b0;
  endtask

  // waits for completion; checks busy stays high (R8)
  task automatic finish_op(output logic got_err, output bit busy_ok);
    busy_ok = 1;
    got_err = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      if (!busy) busy_ok = 0;
      @(negedge clk);
    end
    got_err = err;
    chk(done ^ err, "R8 completion pulse", int'({done, err}), 1);
    chk(!busy, "R8 busy falls with pulse", int'(busy), 0);
  endtask

  initial begin
    logic e;
    bit bok;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_valid, "R1 reset state",
        int'({busy, done, err, bus_valid}), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      load(VEC[v].act0, VEC[v].rd, VEC[v].gd);
      pulse(VEC[v].op, !VEC[v].op);
      finish_op(e, bok);
      chk(bok, "R8 busy held", 0, 1);
      chk(e == VEC[v].e_err, "R7 outcome", int'(e), int'(VEC[v].e_err));
      repeat (3) @(negedge clk);
      chk(n_rel == VEC[v].e_rel, "R3 release writes", n_rel, int'(VEC[v].e_rel));
      chk(n_req == VEC[v].e_req, VEC[v].op ? "R4 request writes" : "R6 no request",
          n_req, int'(VEC[v].e_req));
      chk(n_rdy == VEC[v].e_rdy, VEC[v].op ? "R5 ready writes" : "R6 no ready",
          n_rdy, int'(VEC[v].e_rdy));
      chk(m_act == VEC[v].e_act, "R3 final active", int'(m_act), int'(VEC[v].e_act));
      chk(n_bad == 0, "R9 bus target", n_bad, 0);
    end

    // R7 poll spacing
    load(1'b0, 8'd0, 8'd3);
    pulse(1'b1, 1'b0);
    finish_op(e, bok);
    chk(min_gap >= 16'(GAP), "R7 poll spacing", int'(min_gap), GAP);

    // R2 requests while busy are ignored
    load(1'b0, 8'd0, 8'd3);
    pulse(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0);
    finish_op(e, bok);
    repeat (40) @(negedge clk);
    chk(n_fin == 1, "R2 single completion", n_fin, 1);
    chk(n_req == 1 && n_rdy == 1 && n_rel == 0, "R2 no extra traffic",
        n_req * 100 + n_rdy * 10 + n_rel, 110);
    chk(m_act == 1'b1, "R2 close ignored", int'(m_act), 1);

    // R2 simultaneous requests: open wins
    load(1'b1, 8'd0, 8'd0);
    pulse(1'b1, 1'b1);
    finish_op(e, bok);
    repeat (3) @(negedge clk);
    chk(n_rdy == 1 && n_rel == 1, "R2 open precedence", n_rdy * 10 + n_rel, 11);

    // R1 reset mid-operation
    load(1'b0, 8'd0, 8'd255);
    pulse(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !bus_valid, "R1 reset aborts",
        int'({busy, done, err, bus_valid}), 0);
    rst = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule